// File: doc/BRIEF.md
# Scaler Event Builder with Multi-Event Buffer

The block sits behind a bank of latched scaler counters. Each accepted trigger takes a snapshot of the counter bank, the per-channel enable mask, the time-tag enable and the current time tag. The block then writes one variable-length event into an internal 32-bit multi-event FIFO. An event opens with a header word. An optional time-tag word follows, and then the counter values of the enabled channels, lowest channel first. A read port lets downstream logic drain the FIFO one word at a time. A clear input empties it.

A trigger is accepted only when the builder is idle and the FIFO has room for a whole event under the current settings. The full status compares the free words with the event size that the mask and tag enable would produce now. Several events can wait in the FIFO before any of them is read. A builder state machine with four states does the work. `IDLE` waits for an accepted trigger (transition *accept*: IDLE to HDR). `HDR` writes the header and moves to `TAG` when a tag is wanted (*tag_on*), otherwise to `CHAN` (*tag_off*). `TAG` writes the time tag and moves to `CHAN` (*tag_done*). `CHAN` spends one cycle on every channel index and writes a word only for enabled channels. After the last index it returns to `IDLE` (*scan_done*). A clear from any state returns to `IDLE` (*abort*).

Top module: `scaler_event_builder`

## Requirements
- R1: After reset the FIFO is empty (`empty_o`=1), `busy_o`=0 and `full_o`=0, and the first event written carries event number 0.
- R2: An event is written as the header, then the time tag word when the tag was enabled at acceptance, then the counter words of the enabled channels (mask bit = 1) in ascending channel order. Channel n's counter is `cnt_bank_i[32n+31:32n]`.
- R3: Header bit 31 is 1 when a time tag word follows and 0 when it does not.
- R4: Header bits [15:0] hold the event size in 32-bit words, which is 1 + tag + number of enabled channels.
- R5: Header bits [30:16] hold the event number. It advances by one, modulo 2^15, for each event fully written.
- R6: The counter values, mask, tag enable and time tag are those present in the accepting cycle. Later changes do not alter the event.
- R7: A trigger that arrives while an event is being built is ignored and produces no words.
- R8: `full_o` is 1 exactly when the free FIFO words are fewer than the size of an event under the current mask and tag enable. A trigger while `full_o`=1 is refused: nothing is written and the event number does not advance.
- R9: Several events can be stored before reading and are read back in trigger order.
- R10: `clear_i` empties the FIFO and abandons an event in progress. An abandoned event does not advance the event number.
- R11: `rd_data_o` shows the oldest stored word while `empty_o`=0. `rd_en_i` removes it. `rd_en_i` while empty has no effect.
- R12: `busy_o` is high for exactly 1 + tag + NUM_CH cycles after an accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger request, one cycle |
| tag_en_i | input | 1 | Include the time tag word |
| chan_en_i | input | NUM_CH | Per-channel enable mask |
| cnt_bank_i | input | NUM_CH*32 | Latched counter values, channel n at [32n+31:32n] |
| time_tag_i | input | 32 | Current time tag |
| clear_i | input | 1 | Empty the FIFO and abort building |
| rd_en_i | input | 1 | Remove the word shown on rd_data_o |
| rd_data_o | output | 32 | Oldest word in the FIFO |
| empty_o | output | 1 | FIFO holds no words |
| full_o | output | 1 | Not enough room for one event |
| busy_o | output | 1 | An event is being built |

## Verification
A trigger driven before edge k is accepted at edge k. `busy_o` rises at that edge and stays high for 1 + tag + NUM_CH edges. The header lands in the FIFO at edge k+1, the tag at k+2, and the channel words follow one scan position per edge. The bench drives inputs on the falling edge and samples on the falling edge. It reads back only after `busy_o` has dropped, and it counts the busy cycles to check R12. `full_o` and `empty_o` respond to a write, read or clear one edge later, and read data is checked before each `rd_en_i` pulse.

// File: rtl/sevb_pkg.sv
package sevb_pkg;
    localparam int WORD_W  = 32;
    localparam int EVNUM_W = 15;

    typedef enum logic [1:0] {
        B_IDLE,
        B_HDR,
        B_TAG,
        B_CHAN
    } bstate_t;

    // header: [31] tag present, [30:16] event number, [15:0] size in words
    function automatic logic [WORD_W-1:0] pack_header(
        input logic               tag,
        input logic [EVNUM_W-1:0] evn,
        input logic [15:0]        nwords
    );
        return {tag, evn, nwords};
    endfunction
endpackage

// File: rtl/sevb_size.sv
module sevb_size #(
    parameter int NUM_CH = 8,
    parameter int SIZE_W = 4
) (
    input  logic [NUM_CH-1:0] chan_en_i,
    input  logic              tag_en_i,
    output logic [SIZE_W-1:0] size_o
);
    logic [SIZE_W-1:0] acc;

    always_comb begin
        acc = SIZE_W'(1) + SIZE_W'(tag_en_i);
        for (int i = 0; i < NUM_CH; i++) begin
            acc = acc + SIZE_W'(chan_en_i[i]);
        end
        size_o = acc;
    end
endmodule

// File: rtl/sevb_fifo.sv
module sevb_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic [CW-1:0]    count_o
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count_q;
    logic             do_pop, do_push;

    assign empty_o = (count_q == '0);
    assign count_o = count_q;
    assign rdata_o = mem[rd_ptr];
    assign do_pop  = pop_i && !empty_o && !clr_i;
    assign do_push = push_i && !clr_i;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R8: space reservation means a write never meets a full store
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_q < CW'(DEPTH)));

    // R10: clear leaves nothing behind
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o);

    // R11: a read request on an empty store changes nothing
    a_r11_pop_empty_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !clr_i) |=> empty_o);
endmodule

// File: rtl/sevb_builder.sv
module sevb_builder
    import sevb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SIZE_W = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     clear_i,
    input  logic                     tag_en_i,
    input  logic [NUM_CH-1:0]        chan_en_i,
    input  logic [NUM_CH*WORD_W-1:0] cnt_bank_i,
    input  logic [WORD_W-1:0]        time_tag_i,
    input  logic [SIZE_W-1:0]        size_i,
    output logic                     push_o,
    output logic [WORD_W-1:0]        wdata_o,
    output logic                     busy_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    bstate_t              state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic [EVNUM_W-1:0]   evnum_q;
    logic                 snap_tt;
    logic [NUM_CH-1:0]    snap_mask;
    logic [SIZE_W-1:0]    snap_size;
    logic [WORD_W-1:0]    snap_tag;
    logic [WORD_W-1:0]    snap_cnt [NUM_CH];
    logic                 scan_done;

    assign scan_done = (state_q == B_CHAN) && (idx_q == LAST_IDX);
    assign busy_o    = (state_q != B_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            state_q <= B_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, tag_on, tag_off, tag_done, scan_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE: if (start_i) state_d = B_HDR;
            B_HDR:  state_d = snap_tt ? B_TAG : B_CHAN;
            B_TAG:  state_d = B_CHAN;
            B_CHAN: if (idx_q == LAST_IDX) state_d = B_IDLE;
            default: state_d = B_IDLE;
        endcase
    end

    // control snapshot, scan index and event number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            evnum_q   <= '0;
            snap_tt   <= 1'b0;
            snap_mask <= '0;
            snap_size <= '0;
            snap_tag  <= '0;
        end else begin
            if (start_i && state_q == B_IDLE) begin
                idx_q     <= '0;
                snap_tt   <= tag_en_i;
                snap_mask <= chan_en_i;
                snap_size <= size_i;
                snap_tag  <= time_tag_i;
            end else if (state_q == B_CHAN) begin
                idx_q <= idx_q + 1'b1;
            end
            if (scan_done && !clear_i) begin
                evnum_q <= evnum_q + 1'b1;
            end
        end
    end

    // counter bank snapshot, data only
    always_ff @(posedge clk) begin
        if (start_i && state_q == B_IDLE) begin
            for (int i = 0; i < NUM_CH; i++) begin
                snap_cnt[i] <= cnt_bank_i[i*WORD_W +: WORD_W];
            end
        end
    end

    // write port
    always_comb begin
        push_o  = 1'b0;
        wdata_o = '0;
        unique case (state_q)
            B_IDLE: begin
                push_o  = 1'b0;
            end
            B_HDR: begin
                push_o  = 1'b1;
                wdata_o = pack_header(snap_tt, evnum_q, 16'(snap_size));
            end
            B_TAG: begin
                push_o  = 1'b1;
                wdata_o = snap_tag;
            end
            B_CHAN: begin
                push_o  = snap_mask[idx_q];
                wdata_o = snap_cnt[idx_q];
            end
            default: push_o = 1'b0;
        endcase
    end

    // R7: acceptance only from idle
    a_r7_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clear_i) |-> (state_q == B_IDLE));

    // R5: event number only ever steps by one
    a_r5_evnum_step: assert property (@(posedge clk) disable iff (!rst_n)
        (evnum_q != $past(evnum_q)) |-> (evnum_q == $past(evnum_q) + 1'b1));

    // R3: header flag matches the captured tag choice
    a_r3_hdr_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_HDR) |-> (push_o && wdata_o[31] == snap_tt));

    // R4: header size agrees with an independent count
    a_r4_hdr_size: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_HDR) |->
            (wdata_o[15:0] == 16'(32'd1 + 32'(snap_tt) + 32'($countones(snap_mask)))));
endmodule

// File: rtl/scaler_event_builder.sv
module scaler_event_builder
    import sevb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DEPTH  = 64,
    localparam int SIZE_W = $clog2(NUM_CH + 3),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig_i,
    input  logic                     tag_en_i,
    input  logic [NUM_CH-1:0]        chan_en_i,
    input  logic [NUM_CH*32-1:0]     cnt_bank_i,
    input  logic [31:0]              time_tag_i,
    input  logic                     clear_i,
    input  logic                     rd_en_i,
    output logic [31:0]              rd_data_o,
    output logic                     empty_o,
    output logic                     full_o,
    output logic                     busy_o
);
    logic [SIZE_W-1:0] cur_size;
    logic [CW-1:0]     fill;
    logic [31:0]       free_words;
    logic              accept;
    logic              push;
    logic [31:0]       wdata;

    sevb_size #(.NUM_CH(NUM_CH), .SIZE_W(SIZE_W)) u_size (
        .chan_en_i (chan_en_i),
        .tag_en_i  (tag_en_i),
        .size_o    (cur_size)
    );

    assign free_words = 32'(DEPTH) - 32'(fill);
    assign full_o     = (free_words < 32'(cur_size));
    assign accept     = trig_i && !busy_o && !full_o && !clear_i;

    sevb_builder #(.NUM_CH(NUM_CH), .SIZE_W(SIZE_W)) u_build (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .clear_i    (clear_i),
        .tag_en_i   (tag_en_i),
        .chan_en_i  (chan_en_i),
        .cnt_bank_i (cnt_bank_i),
        .time_tag_i (time_tag_i),
        .size_i     (cur_size),
        .push_o     (push),
        .wdata_o    (wdata),
        .busy_o     (busy_o)
    );

    sevb_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clear_i),
        .push_i  (push),
        .wdata_i (wdata),
        .pop_i   (rd_en_i),
        .rdata_o (rd_data_o),
        .empty_o (empty_o),
        .count_o (fill)
    );

    // R8: a refused trigger leaves the builder idle
    a_r8_refused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && full_o && !busy_o) |=> !busy_o);
endmodule

// File: tb/sim_scaler_event_builder.sv
module sim_scaler_event_builder;
    localparam int NCH   = 8;
    localparam int DEPTH = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trig_i = 1'b0;
    logic            tag_en_i = 1'b0;
    logic [NCH-1:0]  chan_en_i = '0;
    logic [NCH*32-1:0] cnt_bank_i = '0;
    logic [31:0]     time_tag_i = '0;
    logic            clear_i = 1'b0;
    logic            rd_en_i = 1'b0;
    logic [31:0]     rd_data_o;
    logic            empty_o, full_o, busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_ev   = 0;

    always #5 clk = ~clk;

    scaler_event_builder #(.NUM_CH(NCH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .tag_en_i(tag_en_i),
        .chan_en_i(chan_en_i), .cnt_bank_i(cnt_bank_i), .time_tag_i(time_tag_i),
        .clear_i(clear_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .empty_o(empty_o), .full_o(full_o), .busy_o(busy_o)
    );

    // vector: bit 8 = tag enable, bits 7:0 = channel mask
    localparam logic [8:0] VEC [6] = '{9'h1FF, 9'h0FF, 9'h100, 9'h000, 9'h181, 9'h05A};

    function automatic logic [31:0] chv(input int ev, input int ch);
        return 32'hC000_0000 | (32'(ev) << 8) | 32'(ch);
    endfunction

    function automatic logic [31:0] ttv(input int ev);
        return 32'h7100_0000 + 32'(ev);
    endfunction

    function automatic int ones(input logic [NCH-1:0] m);
        int c = 0;
        for (int i = 0; i < NCH; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [NCH-1:0] m, input logic tt, input int ev);
        chan_en_i  = m;
        tag_en_i   = tt;
        time_tag_i = ttv(ev);
        for (int c = 0; c < NCH; c++) cnt_bank_i[c*32 +: 32] = chv(ev, c);
    endtask

    task automatic scramble();
        time_tag_i = 32'hBAD0_BAD0;
        for (int c = 0; c < NCH; c++) cnt_bank_i[c*32 +: 32] = 32'hDEAD_0000 | 32'(c);
    endtask

    // fire one trigger and wait out the build, returns busy cycle count
    task automatic fire(input logic [NCH-1:0] m, input logic tt, input int ev, output int cyc);
        @(negedge clk);
        load(m, tt, ev);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        cyc = 0;
        while (busy_o && cyc < 100) begin
            cyc++;
            if (cyc == 1) scramble();
            trig_i = (cyc == 2);   // R7: trigger during build
            @(negedge clk);
        end
        trig_i = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [31:0] exp);
        chk(req, rd_data_o, exp);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic drain(input logic [NCH-1:0] m, input logic tt, input int ev);
        logic [31:0] hdr;
        hdr = {tt, 15'(ev), 16'(1 + int'(tt) + ones(m))};
        pop_chk("R3 R4 R5 header", hdr);
        if (tt) pop_chk("R2 R6 time tag", ttv(ev));
        for (int c = 0; c < NCH; c++) begin
            if (m[c]) pop_chk("R2 R6 channel word", chv(ev, c));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", 32'(empty_o), 32'd1);
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 full", 32'(full_o), 32'd0);

        // table walk: R2 R3 R4 R5 R6 R7 R12
        for (int v = 0; v < 6; v++) begin
            fire(VEC[v][7:0], VEC[v][8], exp_ev, cyc);
            chk("R12 busy length", 32'(cyc), 32'(1 + int'(VEC[v][8]) + NCH));
            drain(VEC[v][7:0], VEC[v][8], exp_ev);
            chk("R7 no extra event", 32'(empty_o), 32'd1);
            exp_ev++;
        end

        // R9 R8: fill with six 10-word events
        for (int e = 0; e < 6; e++) begin
            fire(8'hFF, 1'b1, exp_ev + e, cyc);
            if (e == 4) chk("R8 not full at 50 words", 32'(full_o), 32'd0);
        end
        chk("R8 full at 60 words", 32'(full_o), 32'd1);
        @(negedge clk);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        chk("R8 refused trigger", 32'(busy_o), 32'd0);
        chan_en_i = 8'h03;
        tag_en_i  = 1'b0;
        #1;
        chk("R8 small event fits", 32'(full_o), 32'd0);
        fire(8'h03, 1'b0, exp_ev + 6, cyc);
        for (int e = 0; e < 6; e++) drain(8'hFF, 1'b1, exp_ev + e);
        drain(8'h03, 1'b0, exp_ev + 6);
        exp_ev += 7;
        chk("R9 all drained", 32'(empty_o), 32'd1);

        // R11 read while empty
        @(negedge clk);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        chk("R11 empty after idle read", 32'(empty_o), 32'd1);
        fire(8'h10, 1'b1, exp_ev, cyc);
        drain(8'h10, 1'b1, exp_ev);
        exp_ev++;

        // R10 abort in progress
        @(negedge clk);
        load(8'hFF, 1'b1, exp_ev);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R10 abort idle", 32'(busy_o), 32'd0);
        chk("R10 abort empty", 32'(empty_o), 32'd1);
        // R10 clear stored data
        fire(8'h0F, 1'b0, exp_ev, cyc);
        chk("R10 stored before clear", 32'(empty_o), 32'd0);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R10 clear empties", 32'(empty_o), 32'd1);
        exp_ev++;
        fire(8'h80, 1'b0, exp_ev, cyc);
        drain(8'h80, 1'b0, exp_ev);
        chk("R5 final empty", 32'(empty_o), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule